// File: doc/BRIEF.md
# Descriptor Completion Notifier

This block sits in a processing channel and decides what the host hears about once a descriptor has been fully processed. When the channel signals that a descriptor is complete, the block looks at the channel configuration and at two per-descriptor flags: the header's done-request bit and whether the descriptor checked an integrity value. From these it decides whether to pulse a done interrupt, whether to ask the bus master to write the done value back into the descriptor header, and whether to ask for a status writeback.

The two writeback requests are level requests with an acknowledge. Each request stays high until it is acknowledged. The header request is always served before the status request for the same descriptor. While a request is outstanding, the block deasserts its ready output and does not take a new completion. A separate error strobe always produces an error interrupt pulse.

Top module: `cmpl_notify`

## Requirements
- R1: After reset, `cmpl_rdy` is 1 and `hdr_wb_req`, `st_wb_req`, `irq_done` and `irq_err` are all 0.
- R2: With `cfg_sel_mode` = 0, every accepted completion (`done_vld` high while `cmpl_rdy` is high) counts as notifying, whatever the value of `done_req`. With `cfg_irq_en` = 1, `irq_done` is then high for exactly the one cycle after the accepting edge.
- R3: With `cfg_sel_mode` = 1, a completion counts as notifying only when `done_req` = 1. A completion with `done_req` = 0 raises neither `irq_done` nor `hdr_wb_req`.
- R4: With `cfg_irq_en` = 0, a notifying completion does not raise `irq_done`.
- R5: `hdr_wb_req` rises in the cycle after the accepting edge only when the completion is notifying and `cfg_hdr_wb_en` = 1.
- R6: While `hdr_wb_req` is high, `hdr_wb_data[31:24]` holds the fixed done code 8'hFF. `hdr_wb_data[23:0]` holds `hdr_in[23:0]` as captured at the accepting edge. The value stays stable until the acknowledge.
- R7: Each writeback request stays high until its acknowledge is sampled high at a clock edge. It falls in the cycle after that edge. An acknowledge sampled while the request is low has no effect.
- R8: With `cfg_stat_all` = 1, any accepted completion raises `st_wb_req`, independent of the notify mode and of `done_req`.
- R9: With `cfg_stat_icv` = 1, an accepted completion that has `done_icv` = 1 raises `st_wb_req`. With `done_icv` = 0 and `cfg_stat_all` = 0, no status request is made.
- R10: When both writebacks are due, `hdr_wb_req` is served first. `st_wb_req` rises in the cycle after the header acknowledge, and the two requests are never high together.
- R11: An `err_vld` strobe gives an `irq_err` pulse in the next cycle. This holds regardless of the notify mode, `cfg_irq_en` and any pending request.
- R12: `cmpl_rdy` is 0 while any writeback request is outstanding. A `done_vld` seen while `cmpl_rdy` is 0 is ignored: it causes no interrupt, no new request and no change to `hdr_wb_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_irq_en | input | 1 | Enable for the done interrupt |
| cfg_hdr_wb_en | input | 1 | Enable for the header writeback |
| cfg_sel_mode | input | 1 | Notify mode: 0 = every descriptor, 1 = only flagged descriptors |
| cfg_stat_all | input | 1 | Status writeback for every descriptor |
| cfg_stat_icv | input | 1 | Status writeback for integrity-checking descriptors |
| done_vld | input | 1 | Descriptor complete strobe |
| done_req | input | 1 | Done-request bit from the descriptor header |
| done_icv | input | 1 | Descriptor performed an integrity-value check |
| hdr_in | input | 32 | Header word of the completing descriptor |
| err_vld | input | 1 | Processing halted on error |
| cmpl_rdy | output | 1 | Block can accept a completion |
| irq_done | output | 1 | Done interrupt pulse |
| irq_err | output | 1 | Error interrupt pulse |
| hdr_wb_req | output | 1 | Header writeback request |
| hdr_wb_ack | input | 1 | Header writeback acknowledge |
| hdr_wb_data | output | 32 | Header word to write back, done code in the top byte |
| st_wb_req | output | 1 | Status writeback request |
| st_wb_ack | input | 1 | Status writeback acknowledge |

## Verification
The bench drives completions with `done_req` = 0 in both notify modes. A design that ignored the mode would either notify an unflagged descriptor or miss one. It delays the acknowledges and fires a second completion while a request is pending. A design that dropped a request early, or took the stray completion, would show a fallen request or changed header data. The case where both writebacks are due checks that the status request waits for the header acknowledge, since a design that issued them together or in reverse order breaks the ordering. Error strobes are sent with the done interrupt disabled, to catch a design that gates the error interrupt with the done enable.

// File: rtl/cn_pkg.sv
// Shared types for the completion notifier.
// Assumes: a single channel, with one completion outstanding at a time.
package cn_pkg;
    typedef enum logic [1:0] {
        CN_IDLE = 2'd0,
        CN_HDR  = 2'd1,
        CN_STAT = 2'd2
    } cn_state_e;

    // Notification plan for one completion.
    typedef struct packed {
        logic irq;
        logic hdr;
        logic stat;
    } cn_plan_t;
endpackage

// File: rtl/cn_decide.sv
// Decides which notifications a completing descriptor earns.
// Purely combinational. Assumes the configuration is stable around the strobe.
module cn_decide
    import cn_pkg::*;
(
    input  logic     cfg_irq_en,
    input  logic     cfg_hdr_wb_en,
    input  logic     cfg_sel_mode,
    input  logic     cfg_stat_all,
    input  logic     cfg_stat_icv,
    input  logic     done_req,
    input  logic     done_icv,
    output cn_plan_t plan
);
    logic notify;

    // Notify mode: every descriptor, or only those flagged in the header.
    always_comb begin
        notify    = !cfg_sel_mode || done_req;
        plan.irq  = notify && cfg_irq_en;
        plan.hdr  = notify && cfg_hdr_wb_en;
        plan.stat = cfg_stat_all || (cfg_stat_icv && done_icv);
    end
endmodule

// File: rtl/cn_irq.sv
// Produces one-cycle done and error interrupt pulses.
// Assumes: accept is a single-cycle qualified completion.
module cn_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic accept,
    input  logic want_irq,
    input  logic err_vld,
    output logic irq_done,
    output logic irq_err
);
    // Register both pulses so they appear one cycle after the cause.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_done <= 1'b0;
            irq_err  <= 1'b0;
        end else begin
            irq_done <= accept && want_irq;
            irq_err  <= err_vld;
        end
    end

    // The error interrupt follows every error strobe (R11).
    p_err_irq_r11: assert property (@(posedge clk) disable iff (!rst_n)
        err_vld |=> irq_err);
    // A done pulse only follows an accepted completion (R2).
    p_done_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
        irq_done |-> $past(accept));
endmodule

// File: rtl/cn_seq.sv
// Writeback sequencer: issues the header request, then the status request,
// and holds each until it is acknowledged. The header word gets the done code
// in its top CODE_W bits. Assumes the bus master keeps ack low while idle.
module cn_seq
    import cn_pkg::*;
#(
    parameter int          DW        = 32,
    parameter int          CODE_W    = 8,
    parameter logic [CODE_W-1:0] DONE_CODE = 8'hFF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept,
    input  cn_plan_t      plan,
    input  logic [DW-1:0] hdr_in,
    input  logic          hdr_wb_ack,
    input  logic          st_wb_ack,
    output logic          hdr_wb_req,
    output logic [DW-1:0] hdr_wb_data,
    output logic          st_wb_req,
    output logic          rdy
);
    localparam int LOW_W = DW - CODE_W;

    cn_state_e     state_q, state_d;
    logic          stat_pend_q;
    logic [DW-1:0] data_q;

    // Next-state selection for the request sequence.
    always_comb begin
        state_d = state_q;
        case (state_q)
            CN_IDLE: if (accept) begin
                if (plan.hdr)       state_d = CN_HDR;
                else if (plan.stat) state_d = CN_STAT;
            end
            CN_HDR:  if (hdr_wb_ack) state_d = stat_pend_q ? CN_STAT : CN_IDLE;
            CN_STAT: if (st_wb_ack)  state_d = CN_IDLE;
            default: state_d = CN_IDLE;
        endcase
    end

    // State, pending status flag and captured header word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= CN_IDLE;
            stat_pend_q <= 1'b0;
            data_q      <= '0;
        end else begin
            state_q <= state_d;
            if (accept && state_q == CN_IDLE) begin
                stat_pend_q <= plan.stat;
                data_q      <= {DONE_CODE, hdr_in[LOW_W-1:0]};
            end
        end
    end

    assign hdr_wb_req  = (state_q == CN_HDR);
    assign st_wb_req   = (state_q == CN_STAT);
    assign hdr_wb_data = data_q;
    assign rdy         = (state_q == CN_IDLE);

    // Requests hold until acknowledged, with the header word steady (R7).
    p_hdr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_wb_req && !hdr_wb_ack |=> hdr_wb_req && $stable(hdr_wb_data));
    p_st_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        st_wb_req && !st_wb_ack |=> st_wb_req);
    // Never both requests at once (R10).
    p_one_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({hdr_wb_req, st_wb_req}));
    // Status directly after header only on header acknowledge (R10).
    p_order_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_wb_req) && $past(hdr_wb_req) |-> $past(hdr_wb_ack));
    // The top byte of the outgoing header is the done code (R6).
    p_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_wb_req |-> hdr_wb_data[DW-1 -: CODE_W] == DONE_CODE);
endmodule

// File: rtl/cmpl_notify.sv
// Top of the completion notifier. Qualifies the completion strobe with ready,
// decides the notifications, pulses interrupts and sequences the writebacks.
// Assumes: done_vld is taken only while cmpl_rdy is high.
module cmpl_notify
    import cn_pkg::*;
#(
    parameter int          DW        = 32,
    parameter int          CODE_W    = 8,
    parameter logic [CODE_W-1:0] DONE_CODE = 8'hFF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_irq_en,
    input  logic          cfg_hdr_wb_en,
    input  logic          cfg_sel_mode,
    input  logic          cfg_stat_all,
    input  logic          cfg_stat_icv,
    input  logic          done_vld,
    input  logic          done_req,
    input  logic          done_icv,
    input  logic [DW-1:0] hdr_in,
    input  logic          err_vld,
    output logic          cmpl_rdy,
    output logic          irq_done,
    output logic          irq_err,
    output logic          hdr_wb_req,
    input  logic          hdr_wb_ack,
    output logic [DW-1:0] hdr_wb_data,
    output logic          st_wb_req,
    input  logic          st_wb_ack
);
    cn_plan_t plan;
    logic     accept;

    assign accept = done_vld && cmpl_rdy;

    cn_decide u_decide (
        .cfg_irq_en    (cfg_irq_en),
        .cfg_hdr_wb_en (cfg_hdr_wb_en),
        .cfg_sel_mode  (cfg_sel_mode),
        .cfg_stat_all  (cfg_stat_all),
        .cfg_stat_icv  (cfg_stat_icv),
        .done_req      (done_req),
        .done_icv      (done_icv),
        .plan          (plan)
    );

    cn_irq u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .want_irq (plan.irq),
        .err_vld  (err_vld),
        .irq_done (irq_done),
        .irq_err  (irq_err)
    );

    cn_seq #(.DW(DW), .CODE_W(CODE_W), .DONE_CODE(DONE_CODE)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .accept      (accept),
        .plan        (plan),
        .hdr_in      (hdr_in),
        .hdr_wb_ack  (hdr_wb_ack),
        .st_wb_ack   (st_wb_ack),
        .hdr_wb_req  (hdr_wb_req),
        .hdr_wb_data (hdr_wb_data),
        .st_wb_req   (st_wb_req),
        .rdy         (cmpl_rdy)
    );

    // No request may be pending while ready is shown (R12).
    p_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_wb_req || st_wb_req) |-> !cmpl_rdy);
endmodule

// File: tb/cmpl_notify_tb.sv
// Directed bench for the completion notifier. Inputs change at the falling
// edge and outputs are sampled there.
module cmpl_notify_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_irq_en = 0, cfg_hdr_wb_en = 0, cfg_sel_mode = 0;
    logic        cfg_stat_all = 0, cfg_stat_icv = 0;
    logic        done_vld = 0, done_req = 0, done_icv = 0, err_vld = 0;
    logic [31:0] hdr_in = '0;
    logic        hdr_wb_ack = 0, st_wb_ack = 0;
    logic        cmpl_rdy, irq_done, irq_err, hdr_wb_req, st_wb_req;
    logic [31:0] hdr_wb_data;
    int          n_chk = 0, n_bad = 0;

    always #2 clk = ~clk;

    cmpl_notify u_dut (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // Called at a falling edge; returns at the falling edge after acceptance.
    task automatic pulse_done(input logic req, input logic icv, input logic [31:0] hdr);
        done_req = req; done_icv = icv; hdr_in = hdr; done_vld = 1'b1;
        @(negedge clk);
        done_vld = 1'b0;
    endtask

    task automatic ack_hdr();
        hdr_wb_ack = 1'b1;
        @(negedge clk);
        hdr_wb_ack = 1'b0;
    endtask

    task automatic ack_st();
        st_wb_ack = 1'b1;
        @(negedge clk);
        st_wb_ack = 1'b0;
    endtask

    task automatic set_cfg(input logic irq, hdr, mode, sall, sicv);
        cfg_irq_en = irq; cfg_hdr_wb_en = hdr; cfg_sel_mode = mode;
        cfg_stat_all = sall; cfg_stat_icv = sicv;
    endtask

    task automatic t_reset();
        chk("R1 rdy", cmpl_rdy, 1);
        chk("R1 hdr_req", hdr_wb_req, 0);
        chk("R1 st_req", st_wb_req, 0);
        chk("R1 irq_done", irq_done, 0);
        chk("R1 irq_err", irq_err, 0);
    endtask

    task automatic t_every_mode();
        set_cfg(1, 1, 0, 0, 0);
        pulse_done(0, 0, 32'h00123456);
        chk("R2 irq pulse", irq_done, 1);
        chk("R5 hdr req", hdr_wb_req, 1);
        chk("R6 data", hdr_wb_data, 32'hFF123456);
        chk("R12 busy", cmpl_rdy, 0);
        pulse_done(1, 1, 32'h00ABCDEF);   // stray completion while busy
        chk("R2 pulse width", irq_done, 0);
        chk("R7 hold", hdr_wb_req, 1);
        chk("R12 data kept", hdr_wb_data, 32'hFF123456);
        @(negedge clk);
        chk("R12 no irq", irq_done, 0);
        ack_hdr();
        chk("R7 drop", hdr_wb_req, 0);
        chk("R12 no status", st_wb_req, 0);
        chk("R12 ready", cmpl_rdy, 1);
        ack_hdr();                        // acknowledge while idle
        chk("R7 stray ack", {cmpl_rdy, hdr_wb_req, st_wb_req}, 3'b100);
    endtask

    task automatic t_flag_mode();
        set_cfg(1, 1, 1, 0, 0);
        pulse_done(0, 0, 32'h0);
        chk("R3 no irq", irq_done, 0);
        chk("R3 no hdr", hdr_wb_req, 0);
        pulse_done(1, 0, 32'h00000077);
        chk("R3 irq", irq_done, 1);
        chk("R3 hdr", hdr_wb_req, 1);
        chk("R6 low bits", hdr_wb_data, 32'hFF000077);
        ack_hdr();
        chk("R7 drop", hdr_wb_req, 0);
    endtask

    task automatic t_gates();
        set_cfg(0, 1, 0, 0, 0);
        pulse_done(0, 0, 32'h0);
        chk("R4 irq off", irq_done, 0);
        chk("R5 hdr on", hdr_wb_req, 1);
        ack_hdr();
        set_cfg(1, 0, 0, 0, 0);
        pulse_done(1, 0, 32'h0);
        chk("R4 irq on", irq_done, 1);
        chk("R5 hdr off", hdr_wb_req, 0);
        chk("R5 rdy", cmpl_rdy, 1);
    endtask

    task automatic t_status();
        set_cfg(1, 0, 1, 1, 0);
        pulse_done(0, 0, 32'h0);
        chk("R8 status", st_wb_req, 1);
        chk("R8 no irq", irq_done, 0);
        chk("R8 no hdr", hdr_wb_req, 0);
        @(negedge clk);
        chk("R7 st hold", st_wb_req, 1);
        ack_st();
        chk("R7 st drop", st_wb_req, 0);
        set_cfg(1, 0, 1, 0, 1);
        pulse_done(0, 0, 32'h0);
        chk("R9 no icv", st_wb_req, 0);
        pulse_done(0, 1, 32'h0);
        chk("R9 icv", st_wb_req, 1);
        ack_st();
    endtask

    task automatic t_order();
        set_cfg(1, 1, 0, 1, 0);
        pulse_done(0, 0, 32'h00000001);
        chk("R10 hdr first", {hdr_wb_req, st_wb_req}, 2'b10);
        @(negedge clk);
        chk("R10 status waits", st_wb_req, 0);
        ack_hdr();
        chk("R10 then status", {hdr_wb_req, st_wb_req}, 2'b01);
        chk("R12 still busy", cmpl_rdy, 0);
        ack_st();
        chk("R10 idle", {cmpl_rdy, hdr_wb_req, st_wb_req}, 3'b100);
    endtask

    task automatic t_error();
        set_cfg(0, 1, 1, 0, 0);
        err_vld = 1'b1;
        @(negedge clk);
        err_vld = 1'b0;
        chk("R11 err irq", irq_err, 1);
        @(negedge clk);
        chk("R11 err pulse", irq_err, 0);
        pulse_done(1, 0, 32'h0);          // header pending
        err_vld = 1'b1;
        @(negedge clk);
        err_vld = 1'b0;
        chk("R11 err while busy", irq_err, 1);
        ack_hdr();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_every_mode();
        t_flag_mode();
        t_gates();
        t_status();
        t_order();
        t_error();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule